// File: doc/BRIEF.md
# Boot-Sector Map and Protection Unit

This unit sits beside the array controller of a 2 MB flash array whose sectors are not uniform in size. Thirty-one sectors span 64 KB each. One more 64 KB region, at the top or the bottom of the array depending on a build parameter, is cut into four smaller boot sectors of 16 KB, 8 KB, 8 KB and 32 KB. The 16 KB piece always lies at the outermost edge of the array. The unit turns the current target address into a sector index in the same cycle. It then reports whether a program or erase may proceed at that address.

Each sector has one protection bit. A programming port sets or clears one bit per clock edge by naming a sector index with a strobe. A temporary-unprotect input makes every sector writable while it is held, and the stored bits are left alone. A second address port, used during identification reads, selects a sector by its 8 KB-granular block number. That port returns a status byte, 01h for a protected sector and 00h otherwise.

Sectors are numbered in ascending address order, 0 to 34. In the bottom-boot build the numbering is: 16 KB = 0, first 8 KB = 1, second 8 KB = 2, 32 KB = 3, then the 64 KB sectors from 4 to 34. In the top-boot build the 64 KB sectors are 0 to 30, followed by 32 KB = 31, first 8 KB = 32, second 8 KB = 33 and 16 KB = 34.

Top module: `bpu_prot_unit`

## Requirements
- R1: With BOOT_TOP=0 and byte addressing, the byte ranges 000000h–003FFFh, 004000h–005FFFh, 006000h–007FFFh and 008000h–00FFFFh decode to sectors 0, 1, 2 and 3. Any other byte address decodes to 3 plus address/65536.
- R2: With BOOT_TOP=1 and byte addressing, the byte ranges 1FC000h–1FFFFFh, 1FA000h–1FBFFFh, 1F8000h–1F9FFFh and 1F0000h–1F7FFFh decode to sectors 34, 33, 32 and 31. Any lower byte address decodes to address/65536.
- R3: When `word_mode`=1, `addr_i[19:0]` is a 16-bit word address that is decoded as byte address 2×word. `addr_i[20]` is ignored in this mode.
- R4: After reset no sector is protected. `wr_ok_o`=1 for every address and `status_o`=00h for every block.
- R5: A one-cycle `set_stb` carrying index s protects sector s from the next clock edge on. No other sector changes.
- R6: A one-cycle `clr_stb` carrying index s unprotects sector s from the next clock edge on. No other sector changes.
- R7: When `set_stb` and `clr_stb` are high together, the named sector ends up protected.
- R8: A strobe carrying an index of 35 or more changes no protection bit.
- R9: While `tmp_unprot`=1, `wr_ok_o`=1 for every address. The stored bits are unchanged, and `status_o` still reports them.
- R10: `status_o` is 01h when the sector holding word-address block `qry_blk` (word address bits 19:12) is protected, and 00h otherwise. Bits 7:1 are always 0.
- R11: `sector_o` and `wr_ok_o` follow `addr_i` without a clock. A strobe does not affect them until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1: addr_i is a word address; 0: byte address |
| addr_i | input | 21 | Program/erase target address |
| tmp_unprot | input | 1 | Global temporary-unprotect override |
| set_stb | input | 1 | Protect the sector named by stb_sector |
| clr_stb | input | 1 | Unprotect the sector named by stb_sector |
| stb_sector | input | 6 | Sector index carried by the strobes |
| qry_blk | input | 8 | Block number for the protection-status query |
| sector_o | output | 6 | Sector index of addr_i |
| wr_ok_o | output | 1 | Target sector may be programmed or erased |
| status_o | output | 8 | Protection status byte of the queried block |

## Verification
Two functions can meet in one cycle: a strobe updating a protection bit, and the combinational write-permission or status answer for that same sector. The bench raises a strobe at the falling edge while the target address already points into the named sector. Before the rising edge it checks that the answer still shows the old bit, and after the edge that it shows the new one. It also raises set and clear together on one sector, expects the set to win, and then confirms through a full address sweep that only that sector reads as protected.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
    // Default geometry: 2 MB array, 64 KB main sectors, 8 KB decode grain.
    localparam int DEF_ARRAY_AW = 21;
    localparam int DEF_MAIN_AW  = 16;
    localparam int DEF_CHUNK_AW = 13;

    // Boot region is split into four pieces.
    localparam int BOOT_PIECES = 4;

    function automatic int sector_count(input int array_aw, input int main_aw);
        return (1 << (array_aw - main_aw)) - 1 + BOOT_PIECES;
    endfunction

    function automatic int index_width(input int array_aw, input int main_aw);
        return $clog2(sector_count(array_aw, main_aw));
    endfunction
endpackage

// File: rtl/bpu_sector_map.sv
module bpu_sector_map #(
    parameter int ARRAY_AW = bpu_pkg::DEF_ARRAY_AW,
    parameter int MAIN_AW  = bpu_pkg::DEF_MAIN_AW,
    parameter int CHUNK_AW = bpu_pkg::DEF_CHUNK_AW,
    parameter bit BOOT_TOP = 1'b1,
    parameter int IDX_W    = bpu_pkg::index_width(ARRAY_AW, MAIN_AW)
) (
    input  logic [ARRAY_AW-1:0] byte_addr,
    output logic [IDX_W-1:0]    sector
);
    localparam int HI_W  = ARRAY_AW - MAIN_AW;
    localparam int OFF_W = MAIN_AW - CHUNK_AW;
    localparam int CPM   = 1 << OFF_W;          // 8 KB chunks per main sector
    localparam int NMAIN = 1 << HI_W;

    logic [HI_W-1:0]  hi;
    logic [OFF_W-1:0] off;
    logic [1:0]       sub;
    logic             in_boot;

    assign hi  = byte_addr[ARRAY_AW-1:MAIN_AW];
    assign off = byte_addr[MAIN_AW-1:CHUNK_AW];

    generate
        if (BOOT_TOP) begin : g_top
            // Boot region at the highest main slot: 32K, 8K, 8K, 16K upward.
            always_comb begin
                in_boot = (hi == HI_W'(NMAIN - 1));
                if (off < OFF_W'(CPM / 2))            sub = 2'd0;
                else if (off == OFF_W'(CPM / 2))      sub = 2'd1;
                else if (off == OFF_W'(CPM / 2 + 1))  sub = 2'd2;
                else                                  sub = 2'd3;
                sector = in_boot ? (IDX_W'(NMAIN - 1) + IDX_W'(sub)) : IDX_W'(hi);
            end
        end else begin : g_bottom
            // Boot region at slot zero: 16K, 8K, 8K, 32K upward.
            always_comb begin
                in_boot = (hi == '0);
                if (off < OFF_W'(CPM / 4))            sub = 2'd0;
                else if (off == OFF_W'(CPM / 4))      sub = 2'd1;
                else if (off == OFF_W'(CPM / 4 + 1))  sub = 2'd2;
                else                                  sub = 2'd3;
                sector = in_boot ? IDX_W'(sub)
                                 : (IDX_W'(hi) + IDX_W'(bpu_pkg::BOOT_PIECES - 1));
            end
        end
    endgenerate
endmodule

// File: rtl/bpu_prot_regs.sv
module bpu_prot_regs #(
    parameter int NSEC  = 35,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [IDX_W-1:0] stb_sector,
    output logic [NSEC-1:0]  prot_q
);
    typedef struct packed {
        logic [NSEC-1:0] prot;
    } prot_state_t;

    prot_state_t state_d, state_q;
    logic [NSEC-1:0] hit;

    // One-hot decode of the strobe index; indices past the last sector hit nothing.
    generate
        for (genvar g = 0; g < NSEC; g++) begin : g_hit
            assign hit[g] = (stb_sector == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        // Clear first, then set, so a simultaneous pair leaves the bit protected.
        state_d.prot = (state_q.prot & ~(hit & {NSEC{clr_stb}})) | (hit & {NSEC{set_stb}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign prot_q = state_q.prot;
endmodule

// File: rtl/bpu_prot_unit.sv
module bpu_prot_unit #(
    parameter int ARRAY_AW = bpu_pkg::DEF_ARRAY_AW,
    parameter int MAIN_AW  = bpu_pkg::DEF_MAIN_AW,
    parameter int CHUNK_AW = bpu_pkg::DEF_CHUNK_AW,
    parameter bit BOOT_TOP = 1'b1,
    localparam int NSEC    = bpu_pkg::sector_count(ARRAY_AW, MAIN_AW),
    localparam int IDX_W   = bpu_pkg::index_width(ARRAY_AW, MAIN_AW),
    localparam int QRY_W   = ARRAY_AW - CHUNK_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_mode,
    input  logic [ARRAY_AW-1:0] addr_i,
    input  logic                tmp_unprot,
    input  logic                set_stb,
    input  logic                clr_stb,
    input  logic [IDX_W-1:0]    stb_sector,
    input  logic [QRY_W-1:0]    qry_blk,
    output logic [IDX_W-1:0]    sector_o,
    output logic                wr_ok_o,
    output logic [7:0]          status_o
);
    logic [ARRAY_AW-1:0] tgt_byte;
    logic [ARRAY_AW-1:0] qry_byte;
    logic [IDX_W-1:0]    qry_sector;
    logic [NSEC-1:0]     prot_q;

    // Word address is shifted up one bit; the top input bit drops out.
    assign tgt_byte = word_mode ? {addr_i[ARRAY_AW-2:0], 1'b0} : addr_i;
    assign qry_byte = {qry_blk, {CHUNK_AW{1'b0}}};

    bpu_sector_map #(
        .ARRAY_AW(ARRAY_AW), .MAIN_AW(MAIN_AW), .CHUNK_AW(CHUNK_AW),
        .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W)
    ) u_tgt_map (
        .byte_addr(tgt_byte),
        .sector   (sector_o)
    );

    bpu_sector_map #(
        .ARRAY_AW(ARRAY_AW), .MAIN_AW(MAIN_AW), .CHUNK_AW(CHUNK_AW),
        .BOOT_TOP(BOOT_TOP), .IDX_W(IDX_W)
    ) u_qry_map (
        .byte_addr(qry_byte),
        .sector   (qry_sector)
    );

    bpu_prot_regs #(.NSEC(NSEC), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (set_stb),
        .clr_stb   (clr_stb),
        .stb_sector(stb_sector),
        .prot_q    (prot_q)
    );

    assign wr_ok_o  = tmp_unprot | ~prot_q[sector_o];
    assign status_o = {7'b0, prot_q[qry_sector]};
endmodule

// File: rtl/bpu_prot_chk.sv
module bpu_prot_chk #(
    parameter int NSEC  = 35,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             set_stb,
    input logic             clr_stb,
    input logic [IDX_W-1:0] stb_sector,
    input logic             tmp_unprot,
    input logic [IDX_W-1:0] sector_o,
    input logic             wr_ok_o,
    input logic [7:0]       status_o,
    input logic [NSEC-1:0]  prot_q
);
    // R1 / R2: decoded index stays inside the sector table.
    p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sector_o < IDX_W'(NSEC));

    // R5 / R7: a set strobe on a valid index leaves that bit protected.
    p_set_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && stb_sector < IDX_W'(NSEC)) |=> prot_q[$past(stb_sector)]);

    // R6: a lone clear strobe on a valid index unprotects that bit.
    p_clr_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb && stb_sector < IDX_W'(NSEC)) |=> !prot_q[$past(stb_sector)]);

    // R8: no strobe, or an out-of-range index, leaves every bit as it was.
    p_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(set_stb || clr_stb) || stb_sector >= IDX_W'(NSEC)) |=> $stable(prot_q));

    // R9: the override grants write permission everywhere.
    p_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmp_unprot |-> wr_ok_o);

    // R10: status byte carries only bit 0.
    p_status_fmt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:1] == 7'd0);
endmodule

bind bpu_prot_unit bpu_prot_chk #(.NSEC(NSEC), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stb   (set_stb),
    .clr_stb   (clr_stb),
    .stb_sector(stb_sector),
    .tmp_unprot(tmp_unprot),
    .sector_o  (sector_o),
    .wr_ok_o   (wr_ok_o),
    .status_o  (status_o),
    .prot_q    (prot_q)
);

// File: tb/sim_bpu_prot_unit.sv
`timescale 1ns/1ps
module sim_bpu_prot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_mode = 1'b0;
    logic [20:0] addr_i = '0;
    logic        tmp_unprot = 1'b0;
    logic        set_stb = 1'b0;
    logic        clr_stb = 1'b0;
    logic [5:0]  stb_sector = '0;
    logic [7:0]  qry_blk = '0;
    logic [5:0]  sec_t, sec_b;
    logic        ok_t, ok_b;
    logic [7:0]  st_t, st_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    bpu_prot_unit #(.BOOT_TOP(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .addr_i(addr_i),
        .tmp_unprot(tmp_unprot), .set_stb(set_stb), .clr_stb(clr_stb),
        .stb_sector(stb_sector), .qry_blk(qry_blk),
        .sector_o(sec_t), .wr_ok_o(ok_t), .status_o(st_t));

    bpu_prot_unit #(.BOOT_TOP(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .addr_i(addr_i),
        .tmp_unprot(tmp_unprot), .set_stb(set_stb), .clr_stb(clr_stb),
        .stb_sector(stb_sector), .qry_blk(qry_blk),
        .sector_o(sec_b), .wr_ok_o(ok_b), .status_o(st_b));

    // Expected sector from the byte-range tables of R1 and R2.
    function automatic int exp_sec(input bit top, input int ba);
        if (top) begin
            if (ba >= 'h1FC000) return 34;
            if (ba >= 'h1FA000) return 33;
            if (ba >= 'h1F8000) return 32;
            if (ba >= 'h1F0000) return 31;
            return ba / 65536;
        end else begin
            if (ba < 'h4000)  return 0;
            if (ba < 'h6000)  return 1;
            if (ba < 'h8000)  return 2;
            if (ba < 'h10000) return 3;
            return 3 + ba / 65536;
        end
    endfunction

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sweep every 8 KB chunk in both addressing modes. prot_s = protected sector
    // (same index in both builds), -1 for none.
    task automatic sweep(input int prot_s, input bit tu);
        tmp_unprot = tu;
        for (int c = 0; c < 256; c++) begin
            for (int wm = 0; wm < 2; wm++) begin
                int ba = c * 8192 + ((c * 1237) % 4096) * 2;
                int et = exp_sec(1'b1, ba);
                int eb = exp_sec(1'b0, ba);
                word_mode = wm[0];
                addr_i = wm ? (21'(ba >> 1) | 21'h100000) : 21'(ba);
                qry_blk = 8'(c);
                #0.2;
                chk(sec_t == 6'(et), wm ? "R3 top word decode" : "R2 top decode", sec_t, et);
                chk(sec_b == 6'(eb), wm ? "R3 bottom word decode" : "R1 bottom decode", sec_b, eb);
                chk(ok_t == (tu || et != prot_s), tu ? "R9 override top" : "R5 wr_ok top", ok_t,
                    (tu || et != prot_s));
                chk(ok_b == (tu || eb != prot_s), tu ? "R9 override bottom" : "R5 wr_ok bottom", ok_b,
                    (tu || eb != prot_s));
                chk(st_t == ((exp_sec(1'b1, c * 8192) == prot_s) ? 8'h01 : 8'h00),
                    "R10 status top", st_t, (exp_sec(1'b1, c * 8192) == prot_s));
                chk(st_b == ((exp_sec(1'b0, c * 8192) == prot_s) ? 8'h01 : 8'h00),
                    "R10 status bottom", st_b, (exp_sec(1'b0, c * 8192) == prot_s));
            end
        end
        tmp_unprot = 1'b0;
    endtask

    task automatic strobe(input bit s, input bit c, input int idx);
        @(negedge clk);
        set_stb = s; clr_stb = c; stb_sector = 6'(idx);
        @(negedge clk);
        set_stb = 1'b0; clr_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        sweep(-1, 1'b0);                       // R4 reset state, R1, R2, R3

        for (int s = 0; s < 35; s++) begin
            strobe(1'b1, 1'b0, s);             // R5
            if (s % 7 == 0) begin
                sweep(s, 1'b0);
                sweep(s, 1'b1);                // R9 override, bits still reported
            end else begin
                word_mode = 1'b0; qry_blk = 8'd0; tmp_unprot = 1'b0;
                #0.2;
            end
            strobe(1'b0, 1'b1, s);             // R6
        end
        sweep(-1, 1'b0);                       // R6 all cleared again

        // R11: strobe visible only after the edge. Target = top sector 34 (1FC000h).
        @(negedge clk);
        word_mode = 1'b0; addr_i = 21'h1FC000;
        set_stb = 1'b1; stb_sector = 6'd34;
        #0.5;
        chk(ok_t == 1'b1, "R11 before edge", ok_t, 1);
        chk(sec_t == 6'd34, "R11 same-cycle index", sec_t, 34);
        @(negedge clk);
        set_stb = 1'b0;
        #0.2;
        chk(ok_t == 1'b0, "R11 after edge", ok_t, 0);
        strobe(1'b0, 1'b1, 34);

        // R7: set and clear together, set wins.
        strobe(1'b1, 1'b1, 5);
        sweep(5, 1'b0);
        strobe(1'b0, 1'b1, 5);

        // R8: out-of-range indices do nothing.
        strobe(1'b1, 1'b0, 35);
        strobe(1'b1, 1'b0, 63);
        sweep(-1, 1'b0);

        // R4: reset clears protection.
        strobe(1'b1, 1'b0, 12);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        sweep(-1, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule